// File: doc/BRIEF.md
# SPI NOR flash command controller

This block is a single-lane SPI master that turns one host request into a complete serial NOR flash operation. The host picks an operation with a 3-bit select and supplies an address and a byte count. The controller then drives chip select, the serial clock and MOSI, and samples MISO. Write data is pulled one byte at a time through a take strobe. Read data is pushed out with a one-cycle valid strobe. The end of each operation is reported with a one-cycle done pulse, or with an error pulse if the request was rejected.

For program and erase requests, the controller first runs a separate write-enable transaction. It then sends the command. Finally it opens a status-polling transaction and keeps chip select low until the busy bit of the status byte reads clear. A program request that would run past the end of a 256-byte page is refused before any pin moves.

The serial clock runs at half the system clock, so each flash byte takes 16 system cycles. The `ADDR_BYTES` parameter sets the address phase to 3 or 4 bytes; with 4 bytes the whole 32 MB array is reachable. The `GAP_CYCLES` parameter sets the minimum chip-select high time between transactions.

Top module: `spi_nor_ctrl`

## Requirements
- R1: After reset, and whenever the controller is idle, `cs_n` is 1, `sclk` is 0 and `req_ready` is 1. `sclk` is 0 in every cycle in which `cs_n` is 1.
- R2: The controller uses SPI mode 0. Each byte is sent MSB first. MOSI changes only when `sclk` falls and is stable while `sclk` is high. MISO is sampled on the rising edge of `sclk`.
- R3: The `req_op` select sends the following first byte on MOSI: 0 read sends 0x03, 1 fast read sends 0x0B, 2 page program sends 0x02, 3 sector erase (4 KB) sends 0x20, 4 block erase (64 KB) sends 0xD8, 5 chip erase sends 0xC7, 6 status read sends 0x05, 7 write enable sends 0x06.
- R4: Read, fast read, program, sector erase and block erase follow the opcode with `ADDR_BYTES` address bytes taken from `req_addr`, most significant byte first. Status read sends no address.
- R5: Fast read sends one dummy byte (8 clocks) between the address and the first data byte. Plain read has no dummy phase.
- R6: Program, sector erase, block erase and chip erase start with a transaction that holds only 0x06. `cs_n` then stays high for at least `GAP_CYCLES` cycles before the command transaction begins.
- R7: Page program sends `req_len` data bytes taken from `wr_data`. `wr_take` pulses once for each byte consumed. Byte 0 must be on `wr_data` when the request is accepted, and each later byte must be present after the previous pulse.
- R8: Read and fast read deliver `req_len` bytes on `rd_data`, one `rd_valid` pulse per byte, in the order received. Status read delivers exactly one byte, with no polling.
- R9: After program or erase, a new transaction sends 0x05 and then keeps reading status bytes with `cs_n` low. It ends after the first status byte whose bit 0 is 0.
- R10: A program request with `req_len` = 0, or with `req_addr[7:0] + req_len` > 256, is rejected. The same applies to a read or fast read with `req_len` = 0. A rejected request gives a one-cycle `err` pulse, no `done` pulse, and no chip-select activity.
- R11: `req_ready` is low from acceptance until completion. Every accepted request ends with a one-cycle `done` pulse, with `cs_n` high. `done` and `err` are never high together.
- R12: Write enable and chip erase commands consist of the opcode byte alone (8 clocks).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when `req_ready` is high |
| req_ready | output | 1 | Controller idle |
| req_op | input | 3 | Operation select (see R3) |
| req_addr | input | 8*ADDR_BYTES | Flash byte address |
| req_len | input | 9 | Byte count for read or program |
| wr_data | input | 8 | Program data byte |
| wr_take | output | 1 | Pulse: current `wr_data` byte consumed |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Pulse: `rd_data` holds a new byte |
| done | output | 1 | Pulse: operation complete |
| err | output | 1 | Pulse: request rejected |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
The bound checker watches several pin-level rules on every cycle:
- the clock stays low while chip select is high;
- MOSI holds while the serial clock is high;
- a rejected request leaves chip select untouched;
- done arrives only with the controller idle;
- the strobes stay one cycle wide.

Some behaviour can only be shown by the bench's scenarios, run against a behavioural flash model that rebuilds each transaction from the pins. That covers the byte sequences, the write-enable prefix and its gap, the dummy byte, the page-limit decisions at the exact boundary, and the number of status bytes polled before completion.

// File: rtl/spi_nor_ctrl.sv
module spi_nor_ctrl #(
  parameter int ADDR_BYTES = 4,
  parameter int GAP_CYCLES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [2:0]              req_op,
  input  logic [8*ADDR_BYTES-1:0] req_addr,
  input  logic [8:0]              req_len,
  input  logic [7:0]              wr_data,
  output logic                    wr_take,
  output logic [7:0]              rd_data,
  output logic                    rd_valid,
  output logic                    done,
  output logic                    err,
  output logic                    cs_n,
  output logic                    sclk,
  output logic                    mosi,
  input  logic                    miso
);
  localparam int AW = 8 * ADDR_BYTES;
  localparam logic [2:0] OP_RD = 3'd0, OP_FRD = 3'd1, OP_PP = 3'd2, OP_SE = 3'd3,
                         OP_BE = 3'd4, OP_CE = 3'd5, OP_ST = 3'd6, OP_WE = 3'd7;

  typedef enum logic [3:0] {S_IDLE, S_WEN, S_GAP, S_CMD, S_ADR, S_DUM, S_DAT, S_POLL, S_FIN} st_t;

  st_t         st, gap_to;
  logic [3:0]  cnt;
  logic [7:0]  sh, rx;
  logic [AW-1:0] adr;
  logic [2:0]  op, abyte;
  logic [8:0]  left;
  logic        poll_first;

  function automatic logic [7:0] opcode(input logic [2:0] o);
    case (o)
      OP_RD:   return 8'h03;
      OP_FRD:  return 8'h0B;
      OP_PP:   return 8'h02;
      OP_SE:   return 8'h20;
      OP_BE:   return 8'hD8;
      OP_CE:   return 8'hC7;
      OP_ST:   return 8'h05;
      default: return 8'h06;
    endcase
  endfunction

  wire shifting = st inside {S_WEN, S_CMD, S_ADR, S_DUM, S_DAT, S_POLL};
  wire byte_end = shifting && cnt == 4'd15;
  wire needs_wen = req_op inside {OP_PP, OP_SE, OP_BE, OP_CE};
  wire has_addr = op inside {OP_RD, OP_FRD, OP_PP, OP_SE, OP_BE};
  wire page_over = (10'(req_addr[7:0]) + 10'(req_len)) > 10'd256;
  wire bad = ((req_op inside {OP_RD, OP_FRD, OP_PP}) && req_len == 9'd0) ||
             (req_op == OP_PP && page_over);

  assign req_ready = st == S_IDLE;
  assign cs_n = !shifting;
  assign sclk = shifting & cnt[0];
  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; gap_to <= S_CMD; cnt <= '0; sh <= '0; rx <= '0; adr <= '0;
      op <= '0; abyte <= '0; left <= '0; poll_first <= 1'b0;
      rd_data <= '0; rd_valid <= 1'b0; wr_take <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0; err <= 1'b0; rd_valid <= 1'b0; wr_take <= 1'b0;
      if (shifting) begin
        cnt <= cnt + 4'd1;
        if (!cnt[0]) rx <= {rx[6:0], miso};
        else if (cnt != 4'd15) sh <= {sh[6:0], 1'b0};
      end
      case (st)
        S_IDLE: if (req_valid) begin
          if (bad) err <= 1'b1;
          else begin
            op <= req_op; adr <= req_addr; left <= req_len; cnt <= '0;
            if (needs_wen) begin st <= S_WEN; sh <= 8'h06; end
            else begin st <= S_CMD; sh <= opcode(req_op); end
          end
        end
        S_WEN: if (byte_end) begin st <= S_GAP; gap_to <= S_CMD; end
        S_GAP: begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'(GAP_CYCLES - 1)) begin
            cnt <= '0; st <= gap_to; poll_first <= 1'b1;
            sh <= (gap_to == S_CMD) ? opcode(op) : 8'h05;
          end
        end
        S_CMD: if (byte_end) begin
          if (has_addr) begin
            st <= S_ADR; sh <= adr[AW-1 -: 8]; adr <= adr << 8; abyte <= 3'(ADDR_BYTES - 1);
          end else if (op == OP_ST) begin
            st <= S_DAT; sh <= '0; left <= 9'd1;
          end else if (op == OP_CE) begin
            st <= S_GAP; gap_to <= S_POLL;
          end else st <= S_FIN;
        end
        S_ADR: if (byte_end) begin
          if (abyte != 3'd0) begin
            sh <= adr[AW-1 -: 8]; adr <= adr << 8; abyte <= abyte - 3'd1;
          end else if (op == OP_FRD) begin
            st <= S_DUM; sh <= '0;
          end else if (op == OP_RD) begin
            st <= S_DAT; sh <= '0;
          end else if (op == OP_PP) begin
            st <= S_DAT; sh <= wr_data; wr_take <= 1'b1;
          end else begin
            st <= S_GAP; gap_to <= S_POLL;
          end
        end
        S_DUM: if (byte_end) begin st <= S_DAT; sh <= '0; end
        S_DAT: if (byte_end) begin
          left <= left - 9'd1;
          if (op != OP_PP) begin rd_data <= rx; rd_valid <= 1'b1; end
          if (left == 9'd1) begin
            if (op == OP_PP) begin st <= S_GAP; gap_to <= S_POLL; end
            else st <= S_FIN;
          end else if (op == OP_PP) begin
            sh <= wr_data; wr_take <= 1'b1;
          end else sh <= '0;
        end
        S_POLL: if (byte_end) begin
          poll_first <= 1'b0; sh <= '0;
          if (!poll_first && !rx[0]) st <= S_FIN;
        end
        S_FIN: begin done <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module spi_nor_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic done,
  input logic err,
  input logic rd_valid,
  input logic wr_take
);
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R1
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) sclk |-> $stable(mosi)); // R2
  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wr_take |=> !wr_take); // R7
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R8
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) err |-> cs_n && $past(cs_n)); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> cs_n && req_ready); // R11
  AST_DONE_ERR: assert property (@(posedge clk) disable iff (!rst_n) !(done && err)); // R11
endmodule

bind spi_nor_ctrl spi_nor_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .cs_n(cs_n), .sclk(sclk),
  .mosi(mosi), .done(done), .err(err), .rd_valid(rd_valid), .wr_take(wr_take)
);

// File: tb/test_spi_nor_ctrl.sv
module test_spi_nor_ctrl;
  localparam int CLK_NS = 10;
  localparam int AB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [2:0] req_op = '0;
  logic [8*AB-1:0] req_addr = '0;
  logic [8:0] req_len = '0;
  logic [7:0] wr_data, rd_data;
  logic wr_take, rd_valid, done, err, cs_n, sclk, mosi;
  logic miso = 1'b0;

  spi_nor_ctrl #(.ADDR_BYTES(AB), .GAP_CYCLES(2)) i_spi_nor_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data),
    .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
    .err(err), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, errors = 0, mon_err = 0, cyc = 0, takes = 0, hi_cnt = 0, bits = 0;
  int busy_polls = 0;
  bit sim_on = 1'b0, finished = 1'b0;
  logic prev_mosi = 1'b0;
  logic [7:0] shv, pbuf [256];
  logic [7:0] cur[$], log_b[$], rd_q[$];
  int log_n[$], log_off[$], log_bits[$], log_gap[$];

  assign wr_data = pbuf[takes[7:0]];

  function automatic logic [7:0] pat(input int j);
    return 8'((j * 37 + 17) & 255);
  endfunction

  function automatic logic resp_bit();
    int k = bits / 8;
    int b = 7 - bits % 8;
    logic [7:0] v = 8'h00;
    if (cur.size() > 0) begin
      if (cur[0] == 8'h05 && k >= 1) v = (k - 1 < busy_polls) ? 8'h03 : 8'h02;
      else if (cur[0] == 8'h03 && k >= 1 + AB) v = pat(k - 1 - AB);
      else if (cur[0] == 8'h0B && k >= 2 + AB) v = pat(k - 2 - AB);
    end
    return v[b];
  endfunction

  // behavioural flash: rebuild each transaction from the pins
  always @(negedge cs_n) begin
    if (sim_on) log_gap.push_back(hi_cnt);
    hi_cnt = 0; cur.delete(); bits = 0; miso = 1'b0;
  end
  always @(posedge sclk) if (!cs_n) begin
    shv = {shv[6:0], mosi}; bits++;
    if (bits % 8 == 0) cur.push_back(shv);
  end
  always @(negedge sclk) if (!cs_n) miso = resp_bit();
  always @(posedge cs_n) if (sim_on) begin
    log_off.push_back(log_b.size());
    foreach (cur[i]) log_b.push_back(cur[i]);
    log_n.push_back(cur.size());
    log_bits.push_back(bits);
  end

  // per-clock pin rules
  always @(negedge clk) begin
    if (sim_on) begin
      cyc++;
      if (cs_n && sclk) mon_err++;
      if (req_ready && !cs_n) mon_err++;
      if (sclk && mosi != prev_mosi) mon_err++;
      if (done && err) mon_err++;
      if (cs_n) hi_cnt++;
      if (rd_valid) rd_q.push_back(rd_data);
      if (wr_take) takes++;
    end
    prev_mosi = mosi;
  end

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int txb(input int t, input int i);
    return int'(log_b[log_off[t] + i]);
  endfunction

  int res, mid_ready;

  task automatic do_op(input logic [2:0] op, input logic [8*AB-1:0] a, input int len, input int busy);
    busy_polls = busy; takes = 0; rd_q.delete();
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_len = 9'(len);
    @(negedge clk);
    req_valid = 1'b0;
    mid_ready = req_ready;
    res = 0;
    for (int n = 0; n < 20000 && res == 0; n++) begin
      if (done) res = 1;
      else if (err) res = 2;
      else @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic bit addr_ok(input int t, input logic [8*AB-1:0] a);
    for (int i = 0; i < AB; i++)
      if (txb(t, 1 + i) != int'(a[8*(AB-1-i) +: 8])) return 1'b0;
    return 1'b1;
  endfunction

  int base;

  initial begin
    for (int i = 0; i < 256; i++) pbuf[i] = 8'hA0 ^ 8'(i * 3);
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R1", "reset cs_n/sclk", {cs_n, sclk}, 2);
    chk(req_ready === 1'b1 && done === 1'b0, "R1", "reset ready/done", {req_ready, done}, 2);
    rst_n = 1'b1; sim_on = 1'b1;
    @(negedge clk);

    base = log_n.size(); do_op(3'd7, '0, 0, 0);
    chk(res == 1, "R11", "write enable completes", res, 1);
    chk(log_n.size() - base == 1 && log_bits[base] == 8, "R12", "write enable length", log_bits[base], 8);
    chk(txb(base, 0) == 8'h06, "R3", "write enable opcode", txb(base, 0), 8'h06);

    base = log_n.size(); do_op(3'd6, '0, 0, 1);
    chk(log_n.size() - base == 1 && log_n[base] == 2, "R8", "status read bytes", log_n[base], 2);
    chk(txb(base, 0) == 8'h05, "R3", "status opcode", txb(base, 0), 8'h05);
    chk(rd_q.size() == 1 && rd_q[0] == 8'h03, "R8", "status byte", rd_q.size() ? int'(rd_q[0]) : -1, 8'h03);

    base = log_n.size(); do_op(3'd0, 32'h01234567, 3, 0);
    chk(mid_ready == 0, "R11", "ready low while busy", mid_ready, 0);
    chk(txb(base, 0) == 8'h03 && addr_ok(base, 32'h01234567), "R4", "read opcode/address MSB first", txb(base, 1), 8'h01);
    chk(log_n[base] == 1 + AB + 3 && log_bits[base] == 8 * (1 + AB + 3), "R5", "read without dummy", log_n[base], 1 + AB + 3);
    chk(rd_q.size() == 3, "R8", "read byte count", rd_q.size(), 3);
    for (int i = 0; i < 3 && i < rd_q.size(); i++)
      chk(rd_q[i] == pat(i), "R8", "read data", rd_q[i], pat(i));

    base = log_n.size(); do_op(3'd1, 32'h00ABCDEF, 2, 0);
    chk(txb(base, 0) == 8'h0B && addr_ok(base, 32'h00ABCDEF), "R4", "fast read opcode/address", txb(base, 2), 8'hAB);
    chk(log_n[base] == 2 + AB + 2, "R5", "fast read dummy byte", log_n[base], 2 + AB + 2);
    chk(rd_q.size() == 2 && rd_q[0] == pat(0) && rd_q[1] == pat(1), "R5", "fast read data after dummy",
        rd_q.size() ? int'(rd_q[0]) : -1, pat(0));

    base = log_n.size(); do_op(3'd2, 32'h000100F0, 16, 3);
    chk(res == 1 && log_n.size() - base == 3, "R6", "program transaction count", log_n.size() - base, 3);
    chk(txb(base, 0) == 8'h06 && log_n[base] == 1, "R6", "write enable prefix", txb(base, 0), 8'h06);
    chk(log_gap[base + 1] >= 2, "R6", "cs high gap", log_gap[base + 1], 2);
    chk(txb(base + 1, 0) == 8'h02 && addr_ok(base + 1, 32'h000100F0), "R4", "program opcode/address", txb(base + 1, 0), 8'h02);
    chk(log_n[base + 1] == 1 + AB + 16 && takes == 16, "R7", "program data count/takes", takes, 16);
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++) if (txb(base + 1, 1 + AB + i) != int'(pbuf[i])) bad++;
      chk(bad == 0, "R7", "program data bytes", bad, 0);
    end
    chk(txb(base + 2, 0) == 8'h05 && log_n[base + 2] == 5, "R9", "poll until busy clear", log_n[base + 2], 5);

    base = log_n.size(); do_op(3'd2, 32'h00000000, 256, 0);
    chk(res == 1 && log_n[base + 1] == 1 + AB + 256, "R10", "full page accepted", log_n[base + 1], 1 + AB + 256);
    chk(log_n[base + 2] == 2, "R9", "poll ends on first clear", log_n[base + 2], 2);

    base = log_n.size(); do_op(3'd2, 32'h000000F0, 17, 0);
    chk(res == 2 && log_n.size() == base, "R10", "page crossing rejected", res, 2);
    base = log_n.size(); do_op(3'd2, 32'h00000000, 257, 0);
    chk(res == 2 && log_n.size() == base, "R10", "oversize program rejected", res, 2);
    base = log_n.size(); do_op(3'd0, 32'h00000010, 0, 0);
    chk(res == 2 && log_n.size() == base, "R10", "zero length read rejected", res, 2);

    base = log_n.size(); do_op(3'd3, 32'h00345000, 0, 0);
    chk(log_n.size() - base == 3 && txb(base, 0) == 8'h06, "R6", "sector erase prefix", log_n.size() - base, 3);
    chk(txb(base + 1, 0) == 8'h20 && log_n[base + 1] == 1 + AB && addr_ok(base + 1, 32'h00345000), "R3", "sector erase command", txb(base + 1, 0), 8'h20);
    chk(log_n[base + 2] == 2, "R9", "sector erase poll", log_n[base + 2], 2);

    base = log_n.size(); do_op(3'd4, 32'h00010000, 0, 2);
    chk(txb(base + 1, 0) == 8'hD8 && addr_ok(base + 1, 32'h00010000), "R3", "block erase command", txb(base + 1, 0), 8'hD8);
    chk(log_n[base + 2] == 4, "R9", "block erase poll", log_n[base + 2], 4);

    base = log_n.size(); do_op(3'd5, '0, 0, 1);
    chk(txb(base + 1, 0) == 8'hC7 && log_bits[base + 1] == 8, "R12", "chip erase opcode only", log_bits[base + 1], 8);
    chk(log_gap[base + 2] >= 2 && log_n[base + 2] == 3, "R9", "chip erase poll", log_n[base + 2], 3);

    chk(mon_err == 0, "R2", "per-clock pin rules", mon_err, 0);
    chk(req_ready === 1'b1 && cs_n === 1'b1, "R1", "idle at end", {req_ready, cs_n}, 3);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule